// File: doc/BRIEF.md
# Hot-Plug Expander Mirror Controller

This block keeps the hot-plug signals of four downstream switch ports in step with an external I/O expander that sits on a shared SMBus master bus. The slot control logic drives a per-port image of hot-plug outputs into the block. Whenever that image differs from the last value seen, the block writes the complete image to the expander. When the expander pulls its active-low interrupt line, the block reads the complete input image back from the expander and presents it per port to the slot logic.

The block does not drive SMBus wires. It asks a shared byte-level master engine for the bus with a request/grant pair. Once it holds the bus, it hands over one command on a valid/ready channel. The engine answers with a one-cycle response strobe that carries an error bit and the read data. The same engine loads configuration from a serial EEPROM after reset, so the block stays silent until the configuration-done input is high.

The command channel follows the usual back-pressure rules. `cmd_valid` rises only while the bus is both requested and granted. Once raised, it stays high with the opcode, address and write data unchanged until a cycle in which `cmd_ready` is high; that cycle is the handshake. The response side has no ready signal, because the block accepts a response in any cycle while a command is outstanding.

Top module: `hp_expander_ctrl`

## Requirements
- R1: Until `cfg_done` is high, `eng_req` stays low. Output changes and interrupts that arrive in this time are remembered and served afterwards.
- R2: A change of `hp_out_img` produces one write command (`cmd_rd`=0). Its `cmd_wdata` carries the whole output image. An unchanged image produces no command.
- R3: Image changes that arrive while a transaction is in flight are merged. Exactly one further write follows, and it carries the latest image.
- R4: The interrupt is active low (`exp_int_n`=0 means asserted) and passes through a two-stage synchroniser. An asserted interrupt produces a read command (`cmd_rd`=1). A successful response copies `rsp_rdata` to `hp_in_img`.
- R5: If the interrupt is still asserted once a read has finished and the synchroniser has settled, a further read is issued.
- R6: When a write and a read are both pending, the write goes first and the read follows. Neither request is lost.
- R7: `eng_req` rises before any command and stays high until the response of that transaction. `cmd_valid` is high only while `eng_req` and `eng_gnt` are both high.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_rd` and `cmd_wdata` hold their values.
- R9: A response with `rsp_err`=1 sets `err_sticky`, which then stays high until reset. The same transaction is retried once, with the same opcode and data, without giving up the bus.
- R10: A second failure ends the transaction. A failed read leaves `hp_in_img` unchanged, and a failed write is not repeated unless the image changes again.
- R11: `cmd_addr` carries the 7-bit expander address, which is taken from `strap_addr` while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_done | input | 1 | Configuration load has finished |
| strap_addr | input | 7 | Expander bus address strap |
| hp_out_img | input | 8 | Per-port hot-plug outputs (2 bits per port) |
| hp_in_img | output | 8 | Per-port hot-plug inputs (2 bits per port) |
| exp_int_n | input | 1 | Expander interrupt, active low, asynchronous |
| eng_req | output | 1 | Bus request to the master engine |
| eng_gnt | input | 1 | Bus grant from the master engine |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_rd | output | 1 | 1 = read input image, 0 = write output image |
| cmd_addr | output | 7 | Expander address |
| cmd_wdata | output | 8 | Output image to write |
| rsp_valid | input | 1 | Response strobe, one cycle |
| rsp_err | input | 1 | NACK or bus error |
| rsp_rdata | input | 8 | Input image read from the expander |
| err_sticky | output | 1 | An error has been seen since reset |

## Verification
A sequencer stuck outside idle shows up as `eng_req` staying high with no further commands. A lost pending flag shows up as a missing write, found within one transaction time after the image change. A wrong merge or a wrong retry count changes the number of commands seen per stimulus, and a bad snapshot changes the write data. Both are visible at the command channel within a few tens of cycles. A synchroniser or cooldown fault gives extra or missing reads, and the effect also appears at once in the value of `hp_in_img`.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_CMD  = 2'd2,
    ST_WAIT = 2'd3
  } hpx_state_e;
endpackage

// File: rtl/hpx_sync.sv
module hpx_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate
  assign q = chain[STAGES-1];
endmodule

// File: rtl/hpx_change_track.sv
module hpx_change_track #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] img,
  input  logic         take,
  output logic         pend
);
  logic [W-1:0] prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      pend <= 1'b0;
    end else begin
      prev <= img;
      pend <= (pend & ~take) | (img != prev);
    end
  end
endmodule

// File: rtl/hpx_seq.sv
module hpx_seq
  import hpx_pkg::*;
#(
  parameter int OW = 8,
  parameter int IW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_done,
  input  logic          pend_wr,
  input  logic          int_act,
  input  logic [OW-1:0] out_img,
  output logic          take_wr,
  output logic          eng_req,
  input  logic          eng_gnt,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_rd,
  output logic [OW-1:0] cmd_wdata,
  input  logic          rsp_valid,
  input  logic          rsp_err,
  input  logic [IW-1:0] rsp_rdata,
  output logic [IW-1:0] in_img,
  output logic          err_sticky
);
  localparam int GW = $clog2(SYNC_STAGES + 1);
  localparam logic [GW-1:0] GAP_LOAD = GW'(SYNC_STAGES);

  hpx_state_e    st;
  logic          retried;
  logic [GW-1:0] gap;
  logic          may_start;

  assign may_start = (st == ST_IDLE) && (gap == '0) && cfg_done;
  assign take_wr   = may_start && pend_wr;
  assign eng_req   = (st != ST_IDLE);
  assign cmd_valid = (st == ST_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cmd_rd     <= 1'b0;
      cmd_wdata  <= '0;
      retried    <= 1'b0;
      gap        <= '0;
      in_img     <= '0;
      err_sticky <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (gap != '0) gap <= gap - 1'b1;
          else if (take_wr) begin
            cmd_rd    <= 1'b0;
            cmd_wdata <= out_img;
            retried   <= 1'b0;
            st        <= ST_REQ;
          end else if (may_start && int_act) begin
            cmd_rd  <= 1'b1;
            retried <= 1'b0;
            st      <= ST_REQ;
          end
        end
        ST_REQ:  if (eng_gnt) st <= ST_CMD;
        ST_CMD:  if (cmd_ready) st <= ST_WAIT;
        ST_WAIT: begin
          if (rsp_valid) begin
            if (rsp_err) begin
              err_sticky <= 1'b1;
              if (!retried) begin
                retried <= 1'b1;
                st      <= ST_CMD;
              end else begin
                st  <= ST_IDLE;
                gap <= GAP_LOAD;
              end
            end else begin
              if (cmd_rd) in_img <= rsp_rdata;
              st  <= ST_IDLE;
              gap <= GAP_LOAD;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hp_expander_ctrl.sv
module hp_expander_ctrl #(
  parameter int NPORT        = 4,
  parameter int OUT_PER_PORT = 2,
  parameter int IN_PER_PORT  = 2,
  parameter int ADDR_W       = 7,
  parameter int SYNC_STAGES  = 2,
  localparam int OW = NPORT * OUT_PER_PORT,
  localparam int IW = NPORT * IN_PER_PORT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_done,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic [OW-1:0]     hp_out_img,
  output logic [IW-1:0]     hp_in_img,
  input  logic              exp_int_n,
  output logic              eng_req,
  input  logic              eng_gnt,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_rd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [OW-1:0]     cmd_wdata,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [IW-1:0]     rsp_rdata,
  output logic              err_sticky
);
  logic int_n_s, pend_wr, take_wr;
  logic [ADDR_W-1:0] addr_q;

  // address latched from straps for as long as reset is held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= strap_addr;
    else        addr_q <= addr_q;
  end
  assign cmd_addr = addr_q;

  hpx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(exp_int_n), .q(int_n_s)
  );

  hpx_change_track #(.W(OW)) u_track (
    .clk(clk), .rst_n(rst_n), .img(hp_out_img), .take(take_wr), .pend(pend_wr)
  );

  hpx_seq #(.OW(OW), .IW(IW), .SYNC_STAGES(SYNC_STAGES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .pend_wr(pend_wr),
    .int_act(~int_n_s), .out_img(hp_out_img), .take_wr(take_wr),
    .eng_req(eng_req), .eng_gnt(eng_gnt), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .in_img(hp_in_img), .err_sticky(err_sticky)
  );
endmodule

// File: rtl/hp_expander_ctrl_chk.sv
module hp_expander_ctrl_chk #(
  parameter int OW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_done,
  input logic          eng_req,
  input logic          eng_gnt,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_rd,
  input logic [OW-1:0] cmd_wdata,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic          err_sticky
);
  // R1
  idle_before_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_done && !eng_req) |=> !eng_req);
  // R7
  cmd_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (eng_req && eng_gnt));
  // R7
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !rsp_valid) |=> eng_req);
  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_rd) && $stable(cmd_wdata)));
  // R9
  err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !cmd_valid && rsp_valid && rsp_err) |=> err_sticky);
  // R9
  err_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
endmodule

bind hp_expander_ctrl hp_expander_ctrl_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .eng_req(eng_req),
  .eng_gnt(eng_gnt), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .err_sticky(err_sticky)
);

// File: tb/hp_expander_ctrl_tb.sv
module hp_expander_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] STRAP = 7'h27;

  logic clk = 1'b0, rst_n = 1'b0, cfg_done = 1'b0;
  logic [7:0] hp_out_img = '0, hp_in_img, cmd_wdata, rsp_rdata = '0;
  logic exp_int_n = 1'b1, eng_req, eng_gnt = 1'b0, cmd_valid, cmd_ready = 1'b1;
  logic cmd_rd, rsp_valid = 1'b0, rsp_err = 1'b0, err_sticky;
  logic [6:0] cmd_addr;

  hp_expander_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .strap_addr(STRAP),
    .hp_out_img(hp_out_img), .hp_in_img(hp_in_img), .exp_int_n(exp_int_n),
    .eng_req(eng_req), .eng_gnt(eng_gnt), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .err_sticky(err_sticky)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // engine + expander model (owned by this process only)
  int n_wr = 0, n_rd = 0, raise_seen = 0, err_used = 0;
  int raise_req = 0, err_set = 0;
  logic [7:0] rd_img = '0, last_wd = '0;
  logic [6:0] last_addr = '0;
  logic [1:0] hist = '0;
  logic busy = 1'b0, op_rd = 1'b0, int_stick = 1'b0;
  int cd = 0;

  always @(negedge clk) begin
    rsp_valid <= 1'b0;
    eng_gnt   <= eng_req;
    if (raise_req != raise_seen) begin
      exp_int_n  <= 1'b0;
      raise_seen <= raise_req;
    end
    if (!busy && cmd_valid && cmd_ready) begin
      busy <= 1'b1; cd <= 2; op_rd <= cmd_rd;
      hist <= {hist[0], cmd_rd}; last_addr <= cmd_addr;
      if (cmd_rd) n_rd <= n_rd + 1;
      else begin n_wr <= n_wr + 1; last_wd <= cmd_wdata; end
    end else if (busy) begin
      if (cd == 0) begin
        busy <= 1'b0; rsp_valid <= 1'b1; rsp_rdata <= rd_img;
        if (err_used < err_set) begin
          rsp_err <= 1'b1; err_used <= err_used + 1;
        end else begin
          rsp_err <= 1'b0;
          if (op_rd && !int_stick) exp_int_n <= 1'b1;
        end
      end else cd <= cd - 1;
    end
  end

  int n_chk = 0, n_bad = 0;
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // {out[31:24], int[23], rd[22:15], nerr[14:13], dwr[12:11], drd[10:9], hpin[8:1], err[0]}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {8'h5A, 1'b0, 8'h00, 2'd0, 2'd1, 2'd0, 8'h3C, 1'b0},
    {8'h5A, 1'b1, 8'hC3, 2'd0, 2'd0, 2'd1, 8'hC3, 1'b0},
    {8'h0F, 1'b1, 8'h81, 2'd0, 2'd1, 2'd1, 8'h81, 1'b0},
    {8'h0F, 1'b1, 8'h42, 2'd1, 2'd0, 2'd2, 8'h42, 1'b1},
    {8'hF0, 1'b0, 8'h00, 2'd2, 2'd2, 2'd0, 8'h42, 1'b1},
    {8'hF0, 1'b1, 8'h99, 2'd2, 2'd0, 2'd3, 8'h99, 1'b1}
  };

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    check("reset eng_req", eng_req, 0);
    check("reset hp_in", hp_in_img, 0);
    check("reset err", err_sticky, 0);
    rst_n = 1'b1;
    // R1 + R6: both requests pend before configuration completes
    cyc(2);
    hp_out_img = 8'h11; rd_img = 8'h3C; raise_req++;
    cyc(30);
    check("R1 no traffic before cfg", n_wr + n_rd, 0);
    check("R1 eng_req low", eng_req, 0);
    cfg_done = 1'b1;
    cyc(40);
    check("R6 write then read", hist, 2'b01);
    check("R2 one write", n_wr, 1);
    check("R2 full image", last_wd, 8'h11);
    check("R4 one read", n_rd, 1);
    check("R4 input image", hp_in_img, 8'h3C);
    check("R11 address", last_addr, STRAP);

    for (int i = 0; i < NV; i++) begin
      automatic logic [31:0] v = VEC[i];
      automatic int w0 = n_wr, r0 = n_rd;
      rd_img = v[22:15];
      err_set = err_set + int'(v[14:13]);
      hp_out_img = v[31:24];
      if (v[23]) raise_req++;
      cyc(60);
      check($sformatf("R2/R9/R10 writes v%0d", i), n_wr - w0, v[12:11]);
      check($sformatf("R4/R9/R10 reads v%0d", i), n_rd - r0, v[10:9]);
      check($sformatf("R4/R10 hp_in v%0d", i), hp_in_img, v[8:1]);
      check($sformatf("R9 sticky v%0d", i), err_sticky, v[0]);
      if (v[12:11] != 0) check($sformatf("R2 data v%0d", i), last_wd, v[31:24]);
    end

    // R8 + R3: stall the first write, change the image twice meanwhile
    begin
      automatic int w0 = n_wr;
      cmd_ready = 1'b0;
      hp_out_img = 8'h01;
      cyc(6);
      check("R8 valid held", cmd_valid, 1);
      check("R8 data held", cmd_wdata, 8'h01);
      hp_out_img = 8'h02; cyc(2);
      hp_out_img = 8'h03; cyc(4);
      check("R8 still held", cmd_wdata, 8'h01);
      check("R8 no handshake", n_wr - w0, 0);
      cmd_ready = 1'b1;
      cyc(60);
      check("R3 merged writes", n_wr - w0, 2);
      check("R3 latest image", last_wd, 8'h03);
    end

    // R5: interrupt stays asserted across a read
    begin
      automatic int r0 = n_rd;
      int_stick = 1'b1; rd_img = 8'h5C; raise_req++;
      cyc(25);
      int_stick = 1'b0;
      cyc(40);
      check("R5 repeated reads", (n_rd - r0) >= 2, 1);
      check("R5 final image", hp_in_img, 8'h5C);
      check("R7 bus released", eng_req, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule